// File: doc/BRIEF.md
# Port Interrupt Aggregation and Line Steering

This block collects interrupt events for a storage host adapter with several ports. Every port owns a six-bit event-flag register. An event sets its flag, and software clears a flag by writing a one to it. Software chooses which flags may raise the port interrupt through an enable mask. That mask has two addresses: one address only sets bits and the other only clears bits. The same port logic also tracks whether the port is ready to process commands. A command error drops the ready state. A reinitialisation request brings it back after a fixed delay.

Each port reduces its enabled, pending flags to one level-sensitive port interrupt. A global mode bit selects how these interrupts reach the four legacy lines. In merged mode, every port interrupt is ORed onto line 0. In steered mode, each port sends its interrupt to the line named by a two-bit field in its enable register, and each line carries the OR of all ports steered to it.

Port p occupies a 32-byte window at base p*0x20. Its offsets are: control 0x00, port state 0x04, event flags 0x08, slot status 0x0C, enable-set 0x10 and enable-clear 0x14. The global mode register sits at address NPORTS*0x20.

Top module: `port_irq_hub`

## Requirements
- R1: An event input that is high at a clock edge sets its flag at that edge. The flags read at offset 0x08 as bit 0 completion, bit 1 command error, bit 2 port ready rise, bit 3 power-state change, bit 4 PHY-ready change and bit 5 wake signal.
- R2: A write to offset 0x08 clears flag n when data bit n or bit n+16 is one (n = 0..5). Flags written as zero in both positions are left unchanged.
- R3: Control bit 3 selects how the completion flag clears. A read of offset 0x0C returns the completion flag in bit 0. When control bit 3 is 0, that read also clears the flag. When control bit 3 is 1, the read leaves the flag set, and only the write-one clear of R2 removes it.
- R4: If an event and a clear of the same flag fall on the same edge, the flag stays set.
- R5: When the command-error input is high at an edge, port_ready is low after that edge. It stays low until a reinitialisation completes.
- R6: Writing control bit 2 starts reinitialisation. port_ready goes high exactly INIT_CYCLES edges after the write edge, and the ready-rise flag (bit 2) is set at that same edge. Offset 0x04 bit 31 reads port_ready.
- R7: The PHY-ready flag (bit 4) is set on both a rising and a falling change of the phy_rdy input.
- R8: A write of ones to offset 0x10 sets the matching enable bits [5:0] and steering bits [31:30]. A write of ones to offset 0x14 clears them. Bits written as zero are unchanged. A read of either offset returns the mask in bits [5:0] and the steering field in bits [31:30].
- R9: A port interrupt is high exactly while some flag and its enable bit are both one.
- R10: Bit 0 of the global register selects the line mode. When it is 0, irq_line[0] is the OR of all port interrupts and lines 1 to 3 stay low. When it is 1, steering value k (0..3) sends the port interrupt to irq_line[k], and each line is the OR of all ports steered to it.
- R11: After reset, all flags, enables, steering fields, control bits and the global mode read as zero, port_ready is low and all lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; the read side effect happens at the edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| ev_done | input | NPORTS | Command completion event, one bit per port |
| ev_err | input | NPORTS | Command error event |
| ev_pm | input | NPORTS | Power-state change event |
| phy_rdy | input | NPORTS | PHY ready level |
| ev_wake | input | NPORTS | Wake signal received event |
| port_ready | output | NPORTS | Port may process commands |
| irq_line | output | 4 | Legacy interrupt lines A to D |

## Verification
A flag that is stuck, or lost through a bad clear, shows up on the line outputs in the same cycle as the enable or steering change that should reveal it. A wrong steering or mode state shows up as an interrupt on the wrong line as soon as any enabled flag is pending. A fault in the ready sequencer shows on port_ready at the exact edge counted from the request, so an off-by-one delay is caught on the first reinitialisation. A fault in the ready sequencer also shows as a missing or extra ready-rise flag.

// File: rtl/irqhub_pkg.sv
package irqhub_pkg;
  localparam int NCAUSE    = 6;
  localparam int C_DONE    = 0;
  localparam int C_ERR     = 1;
  localparam int C_RDY     = 2;
  localparam int C_PM      = 3;
  localparam int C_PHY     = 4;
  localparam int C_WAKE    = 5;
  localparam int ALIAS_OFS = 16;
  localparam int SPAN_W    = 5;
  localparam int CTL_INIT  = 2;
  localparam int CTL_NOCOR = 3;
  localparam int STEER_LSB = 30;
  localparam int READY_BIT = 31;
  localparam int NLINES    = 4;
  localparam int LSEL_W    = 2;

  localparam logic [SPAN_W-1:0] OFF_CTRL  = 5'h00;
  localparam logic [SPAN_W-1:0] OFF_PSTAT = 5'h04;
  localparam logic [SPAN_W-1:0] OFF_ISTAT = 5'h08;
  localparam logic [SPAN_W-1:0] OFF_SLOT  = 5'h0C;
  localparam logic [SPAN_W-1:0] OFF_ENSET = 5'h10;
  localparam logic [SPAN_W-1:0] OFF_ENCLR = 5'h14;

  typedef logic [NCAUSE-1:0] cause_t;
  typedef logic [LSEL_W-1:0] line_sel_t;
endpackage

// File: rtl/irqhub_rst_sync.sv
module irqhub_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/port_ready_seq.sv
module port_ready_seq #(
  parameter int INIT_CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic err,
  output logic ready,
  output logic busy,
  output logic rise
);
  localparam int CNT_W = (INIT_CYCLES < 2) ? 1 : $clog2(INIT_CYCLES);

  logic             ready_q, ready_d;
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             done_now;

  assign done_now = busy_q && (cnt_q == '0);

  always_comb begin
    ready_d = ready_q;
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (err) begin
      ready_d = 1'b0;
      busy_d  = 1'b0;
    end else if (start) begin
      ready_d = 1'b0;
      busy_d  = 1'b1;
      cnt_en  = 1'b1;
      cnt_d   = CNT_W'(INIT_CYCLES - 1);
    end else if (done_now) begin
      busy_d  = 1'b0;
      ready_d = 1'b1;
    end else if (busy_q) begin
      cnt_en  = 1'b1;
      cnt_d   = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      ready_q <= ready_d;
      busy_q  <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ready = ready_q;
  assign busy  = busy_q;
  assign rise  = done_now && !err && !start;
endmodule

// File: rtl/irq_port_unit.sv
module irq_port_unit
  import irqhub_pkg::*;
#(
  parameter int INIT_CYCLES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [SPAN_W-1:0] offs,
  input  logic              wr,
  input  logic              rd,
  input  logic [31:0]       wdata,
  input  logic              ev_done,
  input  logic              ev_err,
  input  logic              ev_pm,
  input  logic              phy_rdy,
  input  logic              ev_wake,
  output logic [31:0]       rdata,
  output cause_t            stat,
  output line_sel_t         steer,
  output logic              port_irq,
  output logic              port_ready
);
  cause_t    stat_q, stat_d, stat_set, stat_clr;
  cause_t    en_q, en_d;
  line_sel_t steer_q, steer_d;
  logic      nocor_q, nocor_d;
  logic      phy_q;
  logic      wr_ctrl, wr_istat, wr_enset, wr_enclr, rd_slot;
  logic      start, rdy_rise, busy;
  logic      en_upd;
  logic      wdata_unused;

  assign wr_ctrl  = hit && wr && (offs == OFF_CTRL);
  assign wr_istat = hit && wr && (offs == OFF_ISTAT);
  assign wr_enset = hit && wr && (offs == OFF_ENSET);
  assign wr_enclr = hit && wr && (offs == OFF_ENCLR);
  assign rd_slot  = hit && rd && (offs == OFF_SLOT);
  assign start    = wr_ctrl && wdata[CTL_INIT];
  assign en_upd   = wr_enset || wr_enclr;

  assign wdata_unused = ^{wdata[29:22], wdata[15:6], wdata[1:0]};

  port_ready_seq #(.INIT_CYCLES(INIT_CYCLES)) u_rdy (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .err   (ev_err),
    .ready (port_ready),
    .busy  (busy),
    .rise  (rdy_rise)
  );

  always_comb begin
    stat_set         = '0;
    stat_set[C_DONE] = ev_done;
    stat_set[C_ERR]  = ev_err;
    stat_set[C_RDY]  = rdy_rise;
    stat_set[C_PM]   = ev_pm;
    stat_set[C_PHY]  = phy_rdy ^ phy_q;
    stat_set[C_WAKE] = ev_wake;

    stat_clr = '0;
    if (wr_istat)
      stat_clr = wdata[NCAUSE-1:0] | wdata[ALIAS_OFS+NCAUSE-1:ALIAS_OFS];
    if (rd_slot && !nocor_q)
      stat_clr[C_DONE] = 1'b1;

    stat_d = (stat_q & ~stat_clr) | stat_set;
  end

  always_comb begin
    en_d    = en_q;
    steer_d = steer_q;
    if (wr_enset) begin
      en_d    = en_q | wdata[NCAUSE-1:0];
      steer_d = steer_q | wdata[STEER_LSB+LSEL_W-1:STEER_LSB];
    end else if (wr_enclr) begin
      en_d    = en_q & ~wdata[NCAUSE-1:0];
      steer_d = steer_q & ~wdata[STEER_LSB+LSEL_W-1:STEER_LSB];
    end
    nocor_d = wr_ctrl ? wdata[CTL_NOCOR] : nocor_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      phy_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      phy_q  <= phy_rdy;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      steer_q <= '0;
    end else if (en_upd) begin
      en_q    <= en_d;
      steer_q <= steer_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       nocor_q <= 1'b0;
    else if (wr_ctrl) nocor_q <= nocor_d;
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      unique case (offs)
        OFF_CTRL: begin
          rdata[CTL_NOCOR] = nocor_q;
          rdata[CTL_INIT]  = busy;
        end
        OFF_PSTAT: begin
          rdata[READY_BIT] = port_ready;
          rdata[0]         = busy;
        end
        OFF_ISTAT: rdata[NCAUSE-1:0] = stat_q;
        OFF_SLOT:  rdata[0] = stat_q[C_DONE];
        OFF_ENSET, OFF_ENCLR: begin
          rdata[NCAUSE-1:0]                   = en_q;
          rdata[STEER_LSB+LSEL_W-1:STEER_LSB] = steer_q;
        end
        default: rdata = '0;
      endcase
    end
  end

  assign stat     = stat_q;
  assign steer    = steer_q;
  assign port_irq = |(stat_q & en_q);
endmodule

// File: rtl/irq_line_router.sv
module irq_line_router
  import irqhub_pkg::*;
#(
  parameter int NPORTS = 2
) (
  input  logic [NPORTS-1:0]             port_irq,
  input  logic [NPORTS-1:0][LSEL_W-1:0] steer,
  input  logic                          steer_on,
  output logic [NLINES-1:0]             line
);
  for (genvar l = 0; l < NLINES; l++) begin : g_line
    always_comb begin
      line[l] = 1'b0;
      for (int p = 0; p < NPORTS; p++) begin
        if (steer_on) begin
          if (steer[p] == LSEL_W'(l)) line[l] = line[l] | port_irq[p];
        end else if (l == 0) begin
          line[l] = line[l] | port_irq[p];
        end
      end
    end
  end
endmodule

// File: rtl/port_irq_hub.sv
module port_irq_hub
  import irqhub_pkg::*;
#(
  parameter int NPORTS      = 2,
  parameter int INIT_CYCLES = 32,
  parameter int ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPORTS-1:0] ev_done,
  input  logic [NPORTS-1:0] ev_err,
  input  logic [NPORTS-1:0] ev_pm,
  input  logic [NPORTS-1:0] phy_rdy,
  input  logic [NPORTS-1:0] ev_wake,
  output logic [NPORTS-1:0] port_ready,
  output logic [3:0]        irq_line
);
  localparam int PSEL_W = ADDR_W - SPAN_W;

  logic                          rst_q_n;
  logic [PSEL_W-1:0]             psel;
  logic [SPAN_W-1:0]             offs;
  logic [NPORTS-1:0]             port_irq;
  logic [NPORTS-1:0][LSEL_W-1:0] steer_all;
  logic [NPORTS-1:0][NCAUSE-1:0] stat_all;
  logic [NPORTS-1:0][31:0]       unit_rdata;
  logic                          glb_hit, glb_wr;
  logic                          steer_on, steer_on_d;

  assign psel    = bus_addr[ADDR_W-1:SPAN_W];
  assign offs    = bus_addr[SPAN_W-1:0];
  assign glb_hit = (psel == PSEL_W'(NPORTS)) && (offs == OFF_CTRL);
  assign glb_wr  = glb_hit && bus_wr;

  irqhub_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    irq_port_unit #(.INIT_CYCLES(INIT_CYCLES)) u_unit (
      .clk        (clk),
      .rst_n      (rst_q_n),
      .hit        (psel == PSEL_W'(p)),
      .offs       (offs),
      .wr         (bus_wr),
      .rd         (bus_rd),
      .wdata      (bus_wdata),
      .ev_done    (ev_done[p]),
      .ev_err     (ev_err[p]),
      .ev_pm      (ev_pm[p]),
      .phy_rdy    (phy_rdy[p]),
      .ev_wake    (ev_wake[p]),
      .rdata      (unit_rdata[p]),
      .stat       (stat_all[p]),
      .steer      (steer_all[p]),
      .port_irq   (port_irq[p]),
      .port_ready (port_ready[p])
    );
  end

  assign steer_on_d = glb_wr ? bus_wdata[0] : steer_on;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    steer_on <= 1'b0;
    else if (glb_wr) steer_on <= steer_on_d;
  end

  always_comb begin
    bus_rdata = glb_hit ? {31'b0, steer_on} : 32'b0;
    for (int p = 0; p < NPORTS; p++) bus_rdata = bus_rdata | unit_rdata[p];
  end

  irq_line_router #(.NPORTS(NPORTS)) u_router (
    .port_irq (port_irq),
    .steer    (steer_all),
    .steer_on (steer_on),
    .line     (irq_line)
  );
endmodule

// File: rtl/port_irq_hub_chk.sv
module port_irq_hub_chk #(
  parameter int NPORTS = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NPORTS-1:0]       ev_err,
  input logic [NPORTS-1:0]       port_ready,
  input logic [NPORTS-1:0]       port_irq,
  input logic [NPORTS-1:0][1:0]  steer_all,
  input logic [NPORTS-1:0][5:0]  stat_all,
  input logic                    steer_on,
  input logic [3:0]              irq_line
);
  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    // R5
    err_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_err[p] |=> !port_ready[p]);
    // R1
    err_flag_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_err[p] |=> stat_all[p][1]);
    // R6
    ready_rise_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(port_ready[p]) |-> stat_all[p][2]);
    // R10
    steered_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (steer_on && port_irq[p]) |-> irq_line[steer_all[p]]);
    // R10
    merged_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!steer_on && port_irq[p]) |-> irq_line[0]);
  end

  // R10
  merged_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !steer_on |-> (irq_line[3:1] == 3'b000));
  // R9
  line_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_line != 4'b0000) |-> (port_irq != '0));
endmodule

bind port_irq_hub port_irq_hub_chk #(.NPORTS(NPORTS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .ev_err     (ev_err),
  .port_ready (port_ready),
  .port_irq   (port_irq),
  .steer_all  (steer_all),
  .stat_all   (stat_all),
  .steer_on   (steer_on),
  .irq_line   (irq_line)
);

// File: tb/sim_port_irq_hub.sv
module sim_port_irq_hub;
  localparam int NP   = 2;
  localparam int INIT = 4;
  localparam int GLB  = NP * 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic [NP-1:0] ev_done, ev_err, ev_pm, phy_rdy, ev_wake, port_ready;
  logic [3:0]  irq_line;

  int checks = 0;
  int fails  = 0;

  logic [5:0] es [NP];
  logic [5:0] een [NP];
  logic [1:0] est [NP];
  logic       enocor [NP];
  logic       erdy [NP];
  logic       eso;

  always #5 clk = ~clk;

  port_irq_hub #(.NPORTS(NP), .INIT_CYCLES(INIT), .ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_done(ev_done), .ev_err(ev_err), .ev_pm(ev_pm), .phy_rdy(phy_rdy),
    .ev_wake(ev_wake), .port_ready(port_ready), .irq_line(irq_line)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a[7:0]; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a[7:0]; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [3:0] exp_lines();
    logic [3:0] l = 4'b0;
    for (int p = 0; p < NP; p++) begin
      logic pi;
      pi = |(es[p] & een[p]);
      if (!eso) l[0] = l[0] | pi;
      else      l[est[p]] = l[est[p]] | pi;
    end
    return l;
  endfunction

  task automatic fire(input int p, input int n);
    if (n == 2) begin
      wr(p*32 + 'h00, {28'b0, enocor[p], 1'b1, 2'b0});
      repeat (INIT) @(negedge clk);
      erdy[p] = 1'b1;
    end else begin
      @(negedge clk);
      case (n)
        0: ev_done[p] = 1'b1;
        1: ev_err[p]  = 1'b1;
        3: ev_pm[p]   = 1'b1;
        4: phy_rdy[p] = ~phy_rdy[p];
        default: ev_wake[p] = 1'b1;
      endcase
      @(negedge clk);
      ev_done = '0; ev_err = '0; ev_pm = '0; ev_wake = '0;
      if (n == 1) erdy[p] = 1'b0;
    end
    es[p][n] = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    ev_done = '0; ev_err = '0; ev_pm = '0; phy_rdy = '0; ev_wake = '0;
    eso = 1'b0;
    for (int p = 0; p < NP; p++) begin
      es[p] = '0; een[p] = '0; est[p] = '0; enocor[p] = 1'b0; erdy[p] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    for (int p = 0; p < NP; p++) begin
      for (int o = 0; o < 6; o++) begin
        rd(p*32 + o*4, d);
        chk("R11 reg", d, 32'h0);
      end
    end
    rd(GLB, d);
    chk("R11 global", d, 32'h0);
    chk("R11 ready", {30'b0, port_ready}, 32'h0);
    chk("R11 lines", {28'b0, irq_line}, 32'h0);

    // sweep: every port, every cause, every steering value
    for (int p = 0; p < NP; p++) begin
      for (int n = 0; n < 6; n++) begin
        fire(p, n);
        rd(p*32 + 'h08, d);
        chk("R1 flag", d, {26'b0, es[p]});
        chk("R9 masked", {28'b0, irq_line}, {28'b0, exp_lines()});
        if (n == 1) chk("R5 ready", {31'b0, port_ready[p]}, 32'h0);
        if (n == 2) chk("R6 ready", {31'b0, port_ready[p]}, 32'h1);
        wr(p*32 + 'h10, 32'h1 << n);
        een[p][n] = 1'b1;
        rd(p*32 + 'h10, d);
        chk("R8 readback", d, {est[p], 24'b0, een[p]});
        chk("R10 merged", {28'b0, irq_line}, {28'b0, exp_lines()});
        wr(GLB, 32'h1); eso = 1'b1;
        for (int s = 0; s < 4; s++) begin
          wr(p*32 + 'h14, 32'hC000_0000);
          wr(p*32 + 'h10, s << 30);
          est[p] = s[1:0];
          chk("R10 steer", {28'b0, irq_line}, {28'b0, exp_lines()});
        end
        wr(GLB, 32'h0); eso = 1'b0;
        wr(p*32 + 'h08, ((p + n) % 2 == 1) ? (32'h1 << (n + 16)) : (32'h1 << n));
        es[p][n] = 1'b0;
        rd(p*32 + 'h08, d);
        chk("R2 alias clear", d, {26'b0, es[p]});
        chk("R9 cleared", {28'b0, irq_line}, {28'b0, exp_lines()});
        wr(p*32 + 'h14, 32'hC000_003F);
        een[p] = '0; est[p] = '0;
        rd(p*32 + 'h14, d);
        chk("R8 cleared", d, 32'h0);
      end
    end

    // R5 then R6 timing on port 0
    fire(0, 1);
    chk("R5 drop", {31'b0, port_ready[0]}, 32'h0);
    repeat (8) @(negedge clk);
    chk("R5 hold low", {31'b0, port_ready[0]}, 32'h0);
    wr(32'h08, 32'h3F); es[0] = '0;
    wr(32'h00, 32'h4);
    repeat (INIT - 1) @(negedge clk);
    chk("R6 early", {31'b0, port_ready[0]}, 32'h0);
    @(negedge clk);
    chk("R6 on time", {31'b0, port_ready[0]}, 32'h1);
    rd(32'h04, d);
    chk("R6 state reg", d, 32'h8000_0000);
    rd(32'h08, d);
    chk("R6 rise flag", d, 32'h4);
    wr(32'h08, 32'h4_0000);

    // R3 completion clear modes on port 1
    fire(1, 0);
    rd(32'h20 + 'h0C, d);
    chk("R3 slot value", d, 32'h1);
    rd(32'h20 + 'h08, d);
    chk("R3 read clears", d, 32'h0);
    wr(32'h20, 32'h8); enocor[1] = 1'b1;
    fire(1, 0);
    rd(32'h20 + 'h0C, d);
    chk("R3 slot value hold", d, 32'h1);
    rd(32'h20 + 'h08, d);
    chk("R3 read keeps", d, 32'h1);
    wr(32'h20 + 'h08, 32'h1_0000);
    rd(32'h20 + 'h08, d);
    chk("R3 write clears", d, 32'h0);
    es[1] = '0;

    // R4 event beats clear
    @(negedge clk);
    ev_wake[1] = 1'b1;
    bus_addr = 8'h28; bus_wdata = 32'h0020_0020; bus_wr = 1'b1;
    @(negedge clk);
    ev_wake = '0; bus_wr = 1'b0;
    rd(32'h28, d);
    chk("R4 event wins", d, 32'h20);
    wr(32'h28, 32'h20);

    // R2 zeros leave flags alone
    fire(1, 0); fire(1, 3); fire(1, 5);
    wr(32'h28, 32'h8_0000);
    rd(32'h28, d);
    chk("R2 others kept", d, 32'h21);
    wr(32'h28, 32'h3F); es[1] = '0;

    // R7 both directions of PHY change
    fire(0, 4);
    rd(32'h08, d);
    chk("R7 change a", d, 32'h10);
    wr(32'h08, 32'h10);
    fire(0, 4);
    rd(32'h08, d);
    chk("R7 change b", d, 32'h10);
    wr(32'h08, 32'h10); es[0] = '0;

    // R8 set/clear leave zero bits alone
    wr(32'h10, 32'h3); wr(32'h10, 32'h4); wr(32'h10, 32'h0);
    rd(32'h14, d);
    chk("R8 set merge", d, 32'h7);
    wr(32'h14, 32'h1);
    rd(32'h10, d);
    chk("R8 clear one", d, 32'h6);
    wr(32'h14, 32'h3F);

    // R10 several ports on shared and separate lines
    wr(GLB, 32'h1); eso = 1'b1;
    rd(GLB, d);
    chk("R10 mode reg", d, 32'h1);
    fire(0, 5); fire(1, 5);
    wr(32'h10, 32'h8000_0020); een[0] = 6'h20; est[0] = 2'd2;
    wr(32'h30, 32'h8000_0020); een[1] = 6'h20; est[1] = 2'd2;
    chk("R10 shared", {28'b0, irq_line}, {28'b0, exp_lines()});
    wr(32'h34, 32'h8000_0000); wr(32'h30, 32'h4000_0000); est[1] = 2'd1;
    chk("R10 split", {28'b0, irq_line}, {28'b0, exp_lines()});
    wr(32'h08, 32'h20); es[0] = '0;
    chk("R10 one left", {28'b0, irq_line}, {28'b0, exp_lines()});
    wr(GLB, 32'h0); eso = 1'b0;
    chk("R10 merge back", {28'b0, irq_line}, {28'b0, exp_lines()});

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule